// File: doc/BRIEF.md
# SD SPI Command Framer

This block sits on the host side of an SD card link running in SPI mode. It takes one command (a 6-bit index, a 32-bit argument and a response-type select) and sends it as a six-byte frame. The frame's check byte is computed as the frame goes out. The block then hunts for the card's response and collects the status byte and any extra response bytes. When the exchange is over, it reports the result with a one-cycle done pulse.

All serial traffic passes through a byte-exchange port. The block offers one transmit byte at a time, and a bit-level SPI shifter outside the block returns the byte received in the same exchange. Chip-select control, the data-block phases and the card start-up sequence stay with the surrounding logic.

Commands enter on a valid/ready pair. Ready is high only while the block is idle, so the command source simply holds valid and the fields until a cycle in which ready is also high. The byte-exchange port uses the same rule in the other direction. `xfer_req` plays the role of valid. Once it is raised, `xfer_tx` stays fixed until a cycle in which `xfer_ack` is high. That cycle completes the exchange, and `xfer_rx` must be valid in it. The shifter may hold `xfer_ack` low for any number of cycles.

Top module: `sdspi_cmd_engine`

## Requirements
- R1: The first byte exchanged after a command is accepted is the header `{2'b01, index}`, that is 0x40 OR the index.
- R2: Bytes two to five of the frame carry the argument, most significant byte first.
- R3: The sixth frame byte is the 7-bit CRC (polynomial x^7+x^3+1, initial value zero) over the first five bytes, placed in bits 7:1, with bit 0 set to 1.
- R4: After the frame, every byte the block transmits is 0xFF. Received bytes with bit 7 set are discarded, and the first received byte with bit 7 clear becomes `rsp_status`.
- R5: If POLL_LIMIT polled bytes arrive without bit 7 clear, the block ends the command. It reports `rsp_timeout`=1, `rsp_status` equal to the last received byte and `rsp_payload`=0, and it makes no further exchanges.
- R6: For response select 2 (R3/R7), the four bytes that follow the status are assembled big-endian into `rsp_payload`.
- R7: For response select 1 (R2), the one byte that follows the status is returned in `rsp_payload[7:0]`, and the upper bits are zero.
- R8: After a response that did not time out, one more 0xFF idle byte is exchanged. The exception is response select 0 or 3 (plain R1) with index 9, 10, 17, 18, 24 or 25; these end directly after the status.
- R9: `done` is high for exactly one cycle per command. The result outputs are valid in that cycle and hold their values until the next command is accepted.
- R10: `cmd_ready` is high only while no command is in progress. A command is accepted in a cycle with `cmd_valid` and `cmd_ready` both high.
- R11: While `xfer_req` is high and `xfer_ack` is low, `xfer_req` stays high and `xfer_tx` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to accept a command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_rtype | input | 2 | Response select: 0/3 R1, 1 R2, 2 R3/R7 |
| xfer_req | output | 1 | Byte exchange requested |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_ack | input | 1 | Exchange completes this cycle |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |
| done | output | 1 | One-cycle end-of-command pulse |
| rsp_status | output | 8 | Status byte, or the last polled byte on timeout |
| rsp_payload | output | 32 | Extra response bytes |
| rsp_timeout | output | 1 | Response poll ran out |

## Verification
All 64 command indices are run with the plain R1 response. This checks the header encoding, the argument byte order and the CRC on every index. It also checks that the idle byte is skipped for exactly the six data-start indices and kept for all others. A sweep of every response select against 0 up to POLL_LIMIT+1 leading 0xFF bytes covers three cases: a response found on the final allowed poll byte, a response found one byte too late, and the payload assembly for each response type. Two fixed frames with well-known check bytes anchor the CRC to independent constants. Random stalls on the exchange acknowledge show that framing does not depend on how the shifter paces the exchanges.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

  localparam int FRAME_BYTES = 6;

  typedef enum logic [1:0] {
    RT_SHORT  = 2'd0,
    RT_STAT2  = 2'd1,
    RT_WORD   = 2'd2,
    RT_SHORT3 = 2'd3
  } rtype_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_POLL,
    ST_EXTRA,
    ST_GAP
  } state_t;

  // Commands whose status is followed directly by a data phase.
  function automatic logic starts_data(input logic [5:0] idx);
    return (idx == 6'd9)  || (idx == 6'd10) || (idx == 6'd17) ||
           (idx == 6'd18) || (idx == 6'd24) || (idx == 6'd25);
  endfunction

endpackage

// File: rtl/sdspi_crc7.sv
module sdspi_crc7 #(
  parameter int W = 8
) (
  input  logic [6:0]   crc_in,
  input  logic [W-1:0] data,
  output logic [6:0]   crc_out
);
  logic [6:0] chain [0:W];

  assign chain[0] = crc_in;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic fb;
    assign fb = data[W-1-i] ^ chain[i][6];
    assign chain[i+1] = {chain[i][5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  end

  assign crc_out = chain[W];
endmodule

// File: rtl/sdspi_frame_mux.sv
module sdspi_frame_mux (
  input  logic [2:0]  sel,
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  input  logic [6:0]  crc,
  output logic [7:0]  frame_byte
);
  always_comb begin
    case (sel)
      3'd0:    frame_byte = {2'b01, idx};
      3'd1:    frame_byte = arg[31:24];
      3'd2:    frame_byte = arg[23:16];
      3'd3:    frame_byte = arg[15:8];
      3'd4:    frame_byte = arg[7:0];
      3'd5:    frame_byte = {crc, 1'b1};
      default: frame_byte = 8'hFF;
    endcase
  end
endmodule

// File: rtl/sdspi_poll_ctr.sv
module sdspi_poll_ctr #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/sdspi_cmd_engine.sv
module sdspi_cmd_engine
  import sdspi_pkg::*;
#(
  parameter int POLL_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [5:0]  cmd_index,
  input  logic [31:0] cmd_arg,
  input  logic [1:0]  cmd_rtype,
  output logic        xfer_req,
  output logic [7:0]  xfer_tx,
  input  logic        xfer_ack,
  input  logic [7:0]  xfer_rx,
  output logic        done,
  output logic [7:0]  rsp_status,
  output logic [31:0] rsp_payload,
  output logic        rsp_timeout
);
  localparam logic [2:0] LAST_BYTE = 3'(FRAME_BYTES - 1);

  state_t      state;
  rtype_t      rtype_q;
  logic [5:0]  idx_q;
  logic [31:0] arg_q;
  logic [6:0]  crc_q;
  logic [6:0]  crc_nxt;
  logic [2:0]  byte_sel;
  logic [2:0]  extra_left;
  logic [7:0]  frame_byte;
  logic        fire;
  logic        accept;
  logic        poll_last;
  logic        poll_step;
  logic        is_short;

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign xfer_req  = (state != ST_IDLE);
  assign fire      = xfer_req && xfer_ack;
  assign xfer_tx   = (state == ST_SEND) ? frame_byte : 8'hFF;
  assign poll_step = fire && (state == ST_POLL) && xfer_rx[7];
  assign is_short  = (rtype_q == RT_SHORT) || (rtype_q == RT_SHORT3);

  sdspi_crc7 #(.W(8)) u_crc (
    .crc_in  (crc_q),
    .data    (frame_byte),
    .crc_out (crc_nxt)
  );

  sdspi_frame_mux u_mux (
    .sel        (byte_sel),
    .idx        (idx_q),
    .arg        (arg_q),
    .crc        (crc_q),
    .frame_byte (frame_byte)
  );

  sdspi_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .step  (poll_step),
    .last  (poll_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      rtype_q     <= RT_SHORT;
      idx_q       <= '0;
      arg_q       <= '0;
      crc_q       <= '0;
      byte_sel    <= '0;
      extra_left  <= '0;
      done        <= 1'b0;
      rsp_status  <= '0;
      rsp_payload <= '0;
      rsp_timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            idx_q       <= cmd_index;
            arg_q       <= cmd_arg;
            rtype_q     <= rtype_t'(cmd_rtype);
            crc_q       <= '0;
            byte_sel    <= '0;
            rsp_status  <= '0;
            rsp_payload <= '0;
            rsp_timeout <= 1'b0;
            state       <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (fire) begin
            if (byte_sel == LAST_BYTE) begin
              state <= ST_POLL;
            end else begin
              crc_q    <= crc_nxt;
              byte_sel <= byte_sel + 3'd1;
            end
          end
        end
        ST_POLL: begin
          if (fire) begin
            if (!xfer_rx[7]) begin
              rsp_status <= xfer_rx;
              if (rtype_q == RT_STAT2) begin
                extra_left <= 3'd1;
                state      <= ST_EXTRA;
              end else if (rtype_q == RT_WORD) begin
                extra_left <= 3'd4;
                state      <= ST_EXTRA;
              end else if (is_short && starts_data(idx_q)) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else begin
                state <= ST_GAP;
              end
            end else if (poll_last) begin
              rsp_status  <= xfer_rx;
              rsp_timeout <= 1'b1;
              state       <= ST_IDLE;
              done        <= 1'b1;
            end
          end
        end
        ST_EXTRA: begin
          if (fire) begin
            rsp_payload <= {rsp_payload[23:0], xfer_rx};
            extra_left  <= extra_left - 3'd1;
            if (extra_left == 3'd1) state <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (fire) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdspi_cmd_engine_chk.sv
module sdspi_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       xfer_req,
  input logic [7:0] xfer_tx,
  input logic       xfer_ack,
  input logic       done,
  input logic [7:0] rsp_status,
  input logic       rsp_timeout
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xfer_req);

  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !xfer_req);

  a_r1_header_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (xfer_req && xfer_tx[7:6] == 2'b01));

  a_r5_timeout_status: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_timeout) |-> rsp_status[7]);
endmodule

bind sdspi_cmd_engine sdspi_cmd_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .xfer_req    (xfer_req),
  .xfer_tx     (xfer_tx),
  .xfer_ack    (xfer_ack),
  .done        (done),
  .rsp_status  (rsp_status),
  .rsp_timeout (rsp_timeout)
);

// File: tb/sdspi_cmd_engine_tb.sv
module sdspi_cmd_engine_tb;
  localparam int LIMIT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic [1:0]  cmd_rtype = '0;
  logic        xfer_req;
  logic [7:0]  xfer_tx;
  logic        xfer_ack;
  logic [7:0]  xfer_rx;
  logic        done;
  logic [7:0]  rsp_status;
  logic [31:0] rsp_payload;
  logic        rsp_timeout;

  int n_checks = 0;
  int n_fail = 0;
  int xcount;
  int base = 0;
  logic [7:0] lfsr;
  logic       ack_q;
  logic [7:0] script [0:15];
  logic [7:0] txlog [0:63];

  always #4 clk = ~clk;

  sdspi_cmd_engine #(.POLL_LIMIT(LIMIT)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_index (cmd_index), .cmd_arg (cmd_arg), .cmd_rtype (cmd_rtype),
    .xfer_req (xfer_req), .xfer_tx (xfer_tx),
    .xfer_ack (xfer_ack), .xfer_rx (xfer_rx),
    .done (done), .rsp_status (rsp_status),
    .rsp_payload (rsp_payload), .rsp_timeout (rsp_timeout)
  );

  // Card side: stalls the acknowledge at random and replays a script.
  assign xfer_ack = ack_q;
  always_comb begin
    int rel;
    rel = xcount - base - 6;
    if (rel < 0 || rel > 15) xfer_rx = 8'hFF;
    else                     xfer_rx = script[rel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr   <= 8'hA5;
      ack_q  <= 1'b0;
      xcount <= 0;
    end else begin
      lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ack_q <= xfer_req && !ack_q && (lfsr[0] || lfsr[1]);
      if (xfer_req && xfer_ack) begin
        txlog[xcount % 64] <= xfer_tx;
        xcount <= xcount + 1;
      end
    end
  end

  function automatic logic [6:0] crc7_ref(input logic [39:0] m);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb;
      fb = m[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [39:0] act,
                     input logic [39:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [5:0] idx, input logic [31:0] arg,
                     input logic [1:0] rt, input int nff,
                     input logic [7:0] st, input logic [31:0] ex);
    int guard;
    int n;
    int exp_n;
    int nx;
    int gap;
    bit tmo;
    bit post_ff;
    logic [7:0] exp_st;
    logic [31:0] exp_pl;
    logic [7:0] exp_frame [0:5];
    for (int k = 0; k < 16; k++) script[k] = 8'hFF;
    if (nff < 16) script[nff] = st;
    for (int k = 0; k < 4; k++)
      if (nff + 1 + k < 16) script[nff + 1 + k] = ex[31 - 8*k -: 8];

    @(negedge clk);
    base = xcount;
    cmd_index = idx; cmd_arg = arg; cmd_rtype = rt; cmd_valid = 1'b1;
    chk(cmd_ready == 1'b1, "R10 ready when idle", 40'(cmd_ready), 40'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R10 busy after accept", 40'(cmd_ready), 40'd0);
    guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(done == 1'b1, "R9 done reached", 40'(done), 40'd1);

    tmo = (nff >= LIMIT);
    nx  = (rt == 2'd1) ? 1 : (rt == 2'd2) ? 4 : 0;
    gap = ((rt == 2'd0 || rt == 2'd3) &&
           (idx == 9 || idx == 10 || idx == 17 || idx == 18 ||
            idx == 24 || idx == 25)) ? 0 : 1;
    exp_n  = tmo ? 6 + LIMIT : 6 + nff + 1 + nx + gap;
    exp_st = tmo ? 8'hFF : st;
    exp_pl = tmo ? 32'h0 : (rt == 2'd1) ? {24'h0, ex[31:24]} :
             (rt == 2'd2) ? ex : 32'h0;
    exp_frame[0] = {2'b01, idx};
    exp_frame[1] = arg[31:24];
    exp_frame[2] = arg[23:16];
    exp_frame[3] = arg[15:8];
    exp_frame[4] = arg[7:0];
    exp_frame[5] = {crc7_ref({2'b01, idx, arg}), 1'b1};

    n = xcount - base;
    chk(n == exp_n, tmo ? "R5 exchange count" : "R8 exchange count",
        40'(n), 40'(exp_n));
    chk(txlog[base % 64] == exp_frame[0], "R1 header",
        40'(txlog[base % 64]), 40'(exp_frame[0]));
    for (int k = 1; k < 5; k++)
      chk(txlog[(base + k) % 64] == exp_frame[k], "R2 argument byte",
          40'(txlog[(base + k) % 64]), 40'(exp_frame[k]));
    chk(txlog[(base + 5) % 64] == exp_frame[5], "R3 crc byte",
        40'(txlog[(base + 5) % 64]), 40'(exp_frame[5]));
    post_ff = 1'b1;
    for (int k = 6; k < n && k < 64; k++)
      if (txlog[(base + k) % 64] != 8'hFF) post_ff = 1'b0;
    chk(post_ff, "R4 filler bytes", 40'(post_ff), 40'd1);
    chk(rsp_status == exp_st, tmo ? "R5 status" : "R4 status",
        40'(rsp_status), 40'(exp_st));
    chk(rsp_timeout == tmo, "R5 timeout flag", 40'(rsp_timeout), 40'(tmo));
    chk(rsp_payload == exp_pl, (rt == 2'd1) ? "R7 payload" : "R6 payload",
        40'(rsp_payload), 40'(exp_pl));
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", 40'(done), 40'd0);
    chk(rsp_status == exp_st && rsp_payload == exp_pl, "R9 outputs hold",
        {rsp_status, rsp_payload}, {exp_st, exp_pl});
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1 && xfer_req == 1'b0 && done == 1'b0,
        "R10 reset state", {37'd0, cmd_ready, xfer_req, done}, 40'd4);
    rst_n = 1'b1;
    @(negedge clk);

    // Independent anchors for the check byte (R3).
    chk({crc7_ref(40'h4000000000), 1'b1} == 8'h95, "R3 known crc idle",
        40'({crc7_ref(40'h4000000000), 1'b1}), 40'h95);
    chk({crc7_ref(40'h48000001AA), 1'b1} == 8'h87, "R3 known crc ifcond",
        40'({crc7_ref(40'h48000001AA), 1'b1}), 40'h87);
    run(6'd0, 32'h0, 2'd0, 1, 8'h01, 32'h0);
    run(6'd8, 32'h1AA, 2'd2, 2, 8'h01, 32'h000001AA);

    // Every index with plain R1 (R1, R2, R3, R8).
    for (int i = 0; i < 64; i++)
      run(6'(i), {2'(i), 6'(i), ~8'(i), 8'(i * 7), 8'(i ^ 8'h5A)},
          (i % 2 == 0) ? 2'd0 : 2'd3, i % 4, {1'b0, 7'(i)}, 32'hDEADBEEF);

    // Every response select against poll depth (R4, R5, R6, R7, R8).
    for (int rt = 0; rt < 4; rt++)
      for (int d = 0; d <= LIMIT + 1; d++)
        run(6'(17 + rt), 32'h8000_0001 + 32'(d), 2'(rt), d,
            8'(d & 8'h7F), 32'hC0FFEE00 + 32'(rt));

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule